// File: doc/BRIEF.md
# Fault Recurrence Latch Counter

This block watches for repeated discharge-overcurrent trips. Three overcurrent channels sit beside it, and each time any of them trips it sends a one-cycle event. Every event adds one to a recurrence count. While no channel is tripped, the count leaks back down by one for each decrement-delay period that passes with no new trip. A slow timer tick paces that period. When the count reaches a programmable limit, the block latches a fault. If autonomous switch control is enabled, it then asks for the discharge switch to be turned off.

Three sources can clear the latched fault, and each clear also resets the count to zero. The first is a load-removed report and the second is a host recover pulse. The third is a charge-current qualification: the signed current sample must stay at or above a recovery threshold for a programmed number of ticks. Charge-current recovery works only when its configuration bit is set, the switches are in series configuration and the charge switch is on. When the latch clears, the discharge-off request is released only once all three channel status bits are clear.

All outputs are registered and follow the internal count with one clock of latency. Load detection and command decoding are done outside this block.

Top module: `fault_recur_latch`

## Requirements
- R1: After a synchronous reset, `alert`, `latched` and `dsg_off_req` are low and the count is zero.
- R2: Each cycle with `trip_pulse` high adds one to the count. The outputs show the new count one clock after the edge that updated it.
- R3: While `chan_status` is all zero, the fault is not latched and the count is above zero, the count drops by one after every `dec_delay` ticks (a setting of 0 acts as 1). While any status bit is set, the count holds.
- R4: A trip restarts the decrement-delay tick timer from zero.
- R5: The count saturates at 2^CNT_W-1 and never goes below zero.
- R6: `alert` is high exactly when the count is above zero and the fault is not latched.
- R7: The fault latches when the count is nonzero and at or above `latch_limit`. `alert` drops in the same cycle that `latched` rises.
- R8: `dsg_off_req` is high while the fault is latched and `cfg_auto_off` is 1. With `cfg_auto_off` at 0, a latch does not raise it.
- R9: While latched, a `load_removed` or `host_recover` pulse clears the latch and resets the count to zero at the next edge.
- R10: While latched, with `cfg_curr_recov`, `cfg_series` and `chg_on` all 1, `cur_sample >= recov_thresh` (signed) held over `recov_time` ticks (minimum 1) qualifies recovery. The latch clears and the count resets one clock after qualification. A lower sample, or any gate at 0, restarts qualification.
- R11: When the latch clears, `dsg_off_req` falls only if `chan_status` is all zero. Otherwise it stays high until the status bits clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trip_pulse | input | 1 | One-cycle event: some overcurrent channel tripped |
| chan_status | input | NCH | Present tripped status of each overcurrent channel |
| tick | input | 1 | Timebase tick for delays |
| latch_limit | input | CNT_W | Count at which the fault latches |
| dec_delay | input | DLY_W | Ticks per count decrement |
| cur_sample | input | CUR_W | Signed current sample, charge positive |
| recov_thresh | input | CUR_W | Signed charge-recovery threshold |
| recov_time | input | DLY_W | Ticks the current must stay at or above threshold |
| cfg_auto_off | input | 1 | Enables the discharge-off request |
| cfg_curr_recov | input | 1 | Enables charge-current recovery |
| cfg_series | input | 1 | Switches are in series configuration |
| chg_on | input | 1 | Charge switch is on |
| load_removed | input | 1 | Load removal reported |
| host_recover | input | 1 | Host recover command pulse |
| alert | output | 1 | Count nonzero and not latched |
| latched | output | 1 | Latched recurrence fault |
| dsg_off_req | output | 1 | Request to turn the discharge switch off |

## Verification
The bench builds the block with CNT_W=3, DLY_W=4 and CUR_W=8. With a 3-bit count, a burst of nine trips pushes the counter into saturation at 7 with the limit set to its maximum. A 4-bit delay lets the decrement and recovery windows be stepped tick by tick. The 8-bit signed sample makes the threshold boundary cases short: equal, one below, and well above. Every clear path and every recovery gate is reached within a few dozen cycles.

// File: rtl/frl_pkg.sv
package frl_pkg;

  typedef struct packed {
    logic auto_off;
    logic curr_recov;
    logic series;
    logic chg_on;
  } frl_cfg_t;

  typedef enum logic [1:0] {
    CLR_NONE = 2'd0,
    CLR_HOST = 2'd1,
    CLR_LOAD = 2'd2,
    CLR_CURR = 2'd3
  } frl_clr_e;

endpackage

// File: rtl/frl_trip_counter.sv
module frl_trip_counter #(
  parameter int CNT_W = 4,
  parameter int DLY_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             inc,
  input  logic             leak_en,
  input  logic             tick,
  input  logic [DLY_W-1:0] dec_delay,
  output logic [CNT_W-1:0] cnt
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [DLY_W-1:0] tmr;
  logic [DLY_W:0]   tmr_nxt;
  logic [DLY_W:0]   tmr_lim;

  assign tmr_nxt = {1'b0, tmr} + 1'b1;
  assign tmr_lim = (dec_delay == '0) ? (DLY_W+1)'(1) : {1'b0, dec_delay};

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
      tmr <= '0;
    end else if (inc) begin
      if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
      tmr <= '0;
    end else if (leak_en && (cnt != '0)) begin
      if (tick) begin
        if (tmr_nxt >= tmr_lim) begin
          cnt <= cnt - 1'b1;
          tmr <= '0;
        end else begin
          tmr <= tmr_nxt[DLY_W-1:0];
        end
      end
    end else begin
      tmr <= '0;
    end
  end

  assert_count_step_R2: assert property (@(posedge clk) disable iff (rst)
    (!clr && inc && cnt != CNT_MAX) |=> (cnt == $past(cnt) + 1'b1));

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
    (!clr && inc && cnt == CNT_MAX) |=> (cnt == CNT_MAX));

  assert_no_underflow_R5: assert property (@(posedge clk) disable iff (rst)
    (cnt == '0 && !inc) |=> (cnt == '0));

  assert_leak_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!leak_en && !inc && !clr) |=> $stable(cnt));

endmodule

// File: rtl/frl_recov_qual.sv
module frl_recov_qual #(
  parameter int CUR_W = 16,
  parameter int DLY_W = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    gate,
  input  logic                    tick,
  input  logic signed [CUR_W-1:0] sample,
  input  logic signed [CUR_W-1:0] thresh,
  input  logic        [DLY_W-1:0] recov_time,
  output logic                    ok
);

  logic             above;
  logic [DLY_W-1:0] tmr;
  logic [DLY_W:0]   tmr_nxt;
  logic [DLY_W:0]   tmr_lim;

  assign above   = (sample >= thresh);
  assign tmr_nxt = {1'b0, tmr} + 1'b1;
  assign tmr_lim = (recov_time == '0) ? (DLY_W+1)'(1) : {1'b0, recov_time};

  always_ff @(posedge clk) begin
    if (rst || !gate || !above) begin
      tmr <= '0;
      ok  <= 1'b0;
    end else if (tick && !ok) begin
      if (tmr_nxt >= tmr_lim) ok <= 1'b1;
      else                    tmr <= tmr_nxt[DLY_W-1:0];
    end
  end

  assert_gate_blocks_R10: assert property (@(posedge clk) disable iff (rst)
    (!gate || !above) |=> !ok);

  assert_needs_tick_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(ok) |-> $past(tick));

endmodule

// File: rtl/frl_latch_ctrl.sv
module frl_latch_ctrl
  import frl_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter int NCH   = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] limit,
  input  logic [NCH-1:0]   chan_status,
  input  frl_cfg_t         cfg,
  input  logic             load_removed,
  input  logic             host_recover,
  input  logic             curr_ok,
  output logic             clr,
  output logic             latched_q,
  output logic             alert_q,
  output logic             dsg_q
);

  frl_clr_e clr_src;
  logic     set_c;
  logic     latched_d;
  logic     chan_any;

  assign set_c    = (cnt != '0) && (cnt >= limit);
  assign chan_any = |chan_status;

  always_comb begin
    clr_src = CLR_NONE;
    if (latched_q) begin
      if (host_recover)      clr_src = CLR_HOST;
      else if (load_removed) clr_src = CLR_LOAD;
      else if (curr_ok)      clr_src = CLR_CURR;
    end
  end

  assign clr       = (clr_src != CLR_NONE);
  assign latched_d = clr ? 1'b0 : (latched_q | set_c);

  always_ff @(posedge clk) begin
    if (rst) begin
      latched_q <= 1'b0;
      alert_q   <= 1'b0;
      dsg_q     <= 1'b0;
    end else begin
      latched_q <= latched_d;
      alert_q   <= !clr && (cnt != '0) && !latched_d;
      dsg_q     <= (latched_d && cfg.auto_off) || (dsg_q && chan_any);
    end
  end

  assert_alert_excl_R6: assert property (@(posedge clk) disable iff (rst)
    alert_q |-> !latched_q);

  assert_clear_R9: assert property (@(posedge clk) disable iff (rst)
    (latched_q && (load_removed || host_recover)) |=> !latched_q);

  assert_req_source_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(dsg_q) |-> latched_q);

  assert_req_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (dsg_q && chan_any) |=> dsg_q);

endmodule

// File: rtl/fault_recur_latch.sv
module fault_recur_latch
  import frl_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter int DLY_W = 16,
  parameter int CUR_W = 16,
  parameter int NCH   = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    trip_pulse,
  input  logic [NCH-1:0]          chan_status,
  input  logic                    tick,
  input  logic [CNT_W-1:0]        latch_limit,
  input  logic [DLY_W-1:0]        dec_delay,
  input  logic signed [CUR_W-1:0] cur_sample,
  input  logic signed [CUR_W-1:0] recov_thresh,
  input  logic [DLY_W-1:0]        recov_time,
  input  logic                    cfg_auto_off,
  input  logic                    cfg_curr_recov,
  input  logic                    cfg_series,
  input  logic                    chg_on,
  input  logic                    load_removed,
  input  logic                    host_recover,
  output logic                    alert,
  output logic                    latched,
  output logic                    dsg_off_req
);

  frl_cfg_t         cfg;
  logic [CNT_W-1:0] cnt;
  logic             clr;
  logic             latched_q;
  logic             curr_ok;
  logic             leak_en;
  logic             recov_gate;

  assign cfg.auto_off   = cfg_auto_off;
  assign cfg.curr_recov = cfg_curr_recov;
  assign cfg.series     = cfg_series;
  assign cfg.chg_on     = chg_on;

  assign leak_en    = (chan_status == '0) && !latched_q;
  assign recov_gate = latched_q && cfg.curr_recov && cfg.series && cfg.chg_on;

  frl_trip_counter #(.CNT_W(CNT_W), .DLY_W(DLY_W)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .clr       (clr),
    .inc       (trip_pulse),
    .leak_en   (leak_en),
    .tick      (tick),
    .dec_delay (dec_delay),
    .cnt       (cnt)
  );

  frl_recov_qual #(.CUR_W(CUR_W), .DLY_W(DLY_W)) u_qual (
    .clk        (clk),
    .rst        (rst),
    .gate       (recov_gate),
    .tick       (tick),
    .sample     (cur_sample),
    .thresh     (recov_thresh),
    .recov_time (recov_time),
    .ok         (curr_ok)
  );

  frl_latch_ctrl #(.CNT_W(CNT_W), .NCH(NCH)) u_latch (
    .clk          (clk),
    .rst          (rst),
    .cnt          (cnt),
    .limit        (latch_limit),
    .chan_status  (chan_status),
    .cfg          (cfg),
    .load_removed (load_removed),
    .host_recover (host_recover),
    .curr_ok      (curr_ok),
    .clr          (clr),
    .latched_q    (latched_q),
    .alert_q      (alert),
    .dsg_q        (dsg_off_req)
  );

  assign latched = latched_q;

endmodule

// File: tb/test_fault_recur_latch.sv
module test_fault_recur_latch;

  localparam int CNT_W = 3;
  localparam int DLY_W = 4;
  localparam int CUR_W = 8;
  localparam int NCH   = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic trip_pulse = 1'b0;
  logic [NCH-1:0] chan_status = '0;
  logic tick = 1'b0;
  logic [CNT_W-1:0] latch_limit = 3'd3;
  logic [DLY_W-1:0] dec_delay = 4'd2;
  logic signed [CUR_W-1:0] cur_sample = '0;
  logic signed [CUR_W-1:0] recov_thresh = 8'sd10;
  logic [DLY_W-1:0] recov_time = 4'd2;
  logic cfg_auto_off = 1'b1;
  logic cfg_curr_recov = 1'b0;
  logic cfg_series = 1'b1;
  logic chg_on = 1'b1;
  logic load_removed = 1'b0;
  logic host_recover = 1'b0;
  logic alert, latched, dsg_off_req;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct {
    logic  a;
    logic  l;
    logic  d;
    string tag;
  } exp_t;
  exp_t sb[$];

  always #5 clk = ~clk;

  fault_recur_latch #(.CNT_W(CNT_W), .DLY_W(DLY_W), .CUR_W(CUR_W), .NCH(NCH)) i_fault_recur_latch (
    .clk(clk), .rst(rst), .trip_pulse(trip_pulse), .chan_status(chan_status),
    .tick(tick), .latch_limit(latch_limit), .dec_delay(dec_delay),
    .cur_sample(cur_sample), .recov_thresh(recov_thresh), .recov_time(recov_time),
    .cfg_auto_off(cfg_auto_off), .cfg_curr_recov(cfg_curr_recov),
    .cfg_series(cfg_series), .chg_on(chg_on), .load_removed(load_removed),
    .host_recover(host_recover), .alert(alert), .latched(latched),
    .dsg_off_req(dsg_off_req)
  );

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic drive(input logic trp, input logic tk);
    trip_pulse = trp;
    tick = tk;
    cyc();
    trip_pulse = 1'b0;
    tick = 1'b0;
  endtask

  task automatic expect_out(input logic a, input logic l, input logic d, input string tag);
    exp_t e;
    e.a = a; e.l = l; e.d = d; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic host_clear();
    host_recover = 1'b1;
    drive(1'b0, 1'b0);
    host_recover = 1'b0;
  endtask

  initial begin
    forever begin
      @(negedge clk);
      while (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if (alert !== e.a || latched !== e.l || dsg_off_req !== e.d) begin
          failures++;
          $display("FAIL %s: got alert=%b latched=%b dsg=%b expected alert=%b latched=%b dsg=%b",
                   e.tag, alert, latched, dsg_off_req, e.a, e.l, e.d);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    cyc(); cyc();
    rst = 1'b0;
    expect_out(0, 0, 0, "R1 reset state");

    drive(1, 0); drive(0, 0);
    expect_out(1, 0, 0, "R2 R6 trip raises alert");

    drive(0, 1); drive(0, 0);
    expect_out(1, 0, 0, "R3 one tick short of delay");
    drive(0, 1); drive(0, 0);
    expect_out(0, 0, 0, "R3 leaked to zero");

    chan_status = 3'b001;
    drive(1, 0);
    for (int i = 0; i < 5; i++) drive(0, 1);
    drive(0, 0);
    expect_out(1, 0, 0, "R3 hold while channel tripped");
    chan_status = '0;
    drive(0, 1); drive(0, 1); drive(0, 0);
    expect_out(0, 0, 0, "R3 leak after status clears");

    drive(1, 0); drive(0, 1); drive(1, 0); drive(0, 1); drive(0, 1); drive(0, 1); drive(0, 0);
    expect_out(1, 0, 0, "R4 trip restarts leak timer");
    drive(0, 1); drive(0, 0);
    expect_out(0, 0, 0, "R4 drained");

    chan_status = 3'b001;
    drive(1, 0); drive(1, 0); drive(0, 0);
    expect_out(1, 0, 0, "R7 below limit");
    drive(1, 0); drive(0, 0);
    expect_out(0, 1, 1, "R7 R8 latch at limit");
    chan_status = '0;
    for (int i = 0; i < 4; i++) drive(0, 1);
    expect_out(0, 1, 1, "R8 request held while latched");

    load_removed = 1'b1; drive(0, 0); load_removed = 1'b0;
    expect_out(0, 0, 0, "R9 load removal clears");
    drive(1, 0); drive(0, 0);
    expect_out(1, 0, 0, "R9 count restarted from zero");
    drive(0, 1); drive(0, 1); drive(0, 0);
    expect_out(0, 0, 0, "R3 drained after R9");

    chan_status = 3'b010;
    drive(1, 0); drive(1, 0); drive(1, 0); drive(0, 0);
    expect_out(0, 1, 1, "R7 relatched");
    host_clear();
    expect_out(0, 0, 1, "R11 request held while status set");
    chan_status = '0;
    drive(0, 0);
    expect_out(0, 0, 0, "R11 request drops after status clears");

    cfg_auto_off = 1'b0;
    chan_status = 3'b001;
    drive(1, 0); drive(1, 0); drive(1, 0); drive(0, 0);
    expect_out(0, 1, 0, "R8 auto off gives no request");
    chan_status = '0;
    host_clear();
    expect_out(0, 0, 0, "R9 host command clears");
    cfg_auto_off = 1'b1;

    cfg_curr_recov = 1'b1;
    cur_sample = 8'sd20;
    drive(1, 0); drive(1, 0); drive(1, 0); drive(0, 0);
    drive(0, 1); drive(0, 0);
    expect_out(0, 1, 1, "R10 not yet qualified");
    drive(0, 1); drive(0, 0);
    expect_out(0, 0, 0, "R10 current recovery clears");

    cur_sample = 8'sd10;
    drive(1, 0); drive(1, 0); drive(1, 0); drive(0, 0);
    drive(0, 1); drive(0, 1); drive(0, 0);
    expect_out(0, 0, 0, "R10 equal to threshold recovers");

    cur_sample = 8'sd9;
    drive(1, 0); drive(1, 0); drive(1, 0); drive(0, 0);
    for (int i = 0; i < 4; i++) drive(0, 1);
    drive(0, 0);
    expect_out(0, 1, 1, "R10 below threshold holds");
    cur_sample = 8'sd20;
    cfg_series = 1'b0;
    for (int i = 0; i < 4; i++) drive(0, 1);
    drive(0, 0);
    expect_out(0, 1, 1, "R10 gated by parallel switches");
    cfg_series = 1'b1;
    chg_on = 1'b0;
    for (int i = 0; i < 4; i++) drive(0, 1);
    drive(0, 0);
    expect_out(0, 1, 1, "R10 gated by charge switch off");
    chg_on = 1'b1;
    cfg_curr_recov = 1'b0;
    for (int i = 0; i < 4; i++) drive(0, 1);
    drive(0, 0);
    expect_out(0, 1, 1, "R10 gated by configuration");
    host_clear();
    expect_out(0, 0, 0, "R9 host clear after gating");

    cur_sample = '0;
    latch_limit = 3'd7;
    chan_status = 3'b001;
    for (int i = 0; i < 9; i++) drive(1, 0);
    drive(0, 0);
    expect_out(0, 1, 1, "R5 saturated burst stays latched");
    chan_status = '0;
    host_clear();
    for (int i = 0; i < 3; i++) drive(0, 1);
    drive(0, 0);
    expect_out(0, 0, 0, "R5 floor at zero");

    drive(0, 0);
    @(negedge clk);
    #1;
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule